// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block watches every external bus transfer that the local master starts and makes sure that the transfer ends in bounded time. When a transfer starts, a timer opens and runs from a free prescaler that divides the system clock by eight. The timer closes when the slave answers with an acknowledge, a transfer error or a retry. If no answer arrives before the programmed limit, the monitor raises its own one-cycle transfer-error strobe so that the stalled cycle can be aborted.

A burst is announced at transfer start by a burst flag and a beat count. Every acknowledge that is not the final one reopens a full timeout window for the next beat. The final acknowledge, a transfer error or a retry closes the cycle. The limit is an 8-bit value counted in units of eight clocks, so the longest window is 2040 clocks.

An enable bit decides whether the monitor may abort a cycle, and it is captured when the transfer starts. A freeze input or a pending debug request forces the monitor active at any time, including part way through a cycle that started while the monitor was disabled.

Top module: `bus_timeout_mon`

## Requirements
- R1: After reset, `tea_o` is low and the monitor is idle.
- R2: The prescaler and the count are cleared by the clock edge that samples `xfer_start`, and `tmo_limit` is captured on that edge as well. With no answer, `tea_o` goes high in the cycle that follows the edge 8*L clocks later, where L is the captured limit. A limit of 0 behaves as 1, so it gives 8 clocks, and 255 gives 2040 clocks.
- R3: An acknowledge, error or retry sampled on or before the deadline edge ends the cycle with no `tea_o`. If the answer and the deadline fall on the same edge, the answer wins.
- R4: When `burst_i` is high at start, the cycle has `beats_m1`+1 beats. Each acknowledge except the last one restarts the prescaler and the count, which gives the next beat a full 8*L window from the edge of that acknowledge.
- R5: The acknowledge of the final beat ends the cycle. A transfer error or a retry ends the whole cycle at any beat. Answers that arrive while the monitor is idle have no effect.
- R6: `tea_o` is a single-cycle pulse. After it, the monitor is idle and gives no further pulse until the next start.
- R7: `mon_en` is sampled at start and held for the rest of the cycle. A cycle that starts with the monitor disabled, and is never forced on, produces no `tea_o`.
- R8: While `freeze_i` or `dbg_req_i` is high, the monitor is active regardless of its enable. If the count is already at or past the limit when the force input rises, `tea_o` follows the next edge.
- R9: A start that arrives during a cycle begins a new cycle and samples the enable, limit and burst inputs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Transfer start, one-cycle strobe |
| xfer_ack | input | 1 | Transfer acknowledge for the current beat |
| xfer_err | input | 1 | Transfer error from the slave |
| xfer_retry | input | 1 | Retry from the slave |
| burst_i | input | 1 | Transfer is a burst, sampled at start |
| beats_m1 | input | BEAT_W | Burst beats minus one, sampled at start |
| mon_en | input | 1 | Monitor enable, sampled at start |
| tmo_limit | input | LIM_W | Timeout in units of eight clocks |
| freeze_i | input | 1 | Freeze, forces the monitor active |
| dbg_req_i | input | 1 | Debug request pending, forces the monitor active |
| tea_o | output | 1 | Internally generated transfer-error pulse |

## Verification
The deadline of a beat and the slave's answer can land on the same clock edge. The bench provokes this by placing an acknowledge exactly 8*L edges after the start, or after a mid-burst restart. It judges the result by checking that no error pulse appears, and in the burst case by checking that the next beat still receives its full window. Placing the answer one edge later shows the opposite outcome: the error pulse appears on the deadline edge and the late answer is ignored.

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon #(
  parameter int PRE_W  = 3,
  parameter int LIM_W  = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              xfer_ack,
  input  logic              xfer_err,
  input  logic              xfer_retry,
  input  logic              burst_i,
  input  logic [BEAT_W-1:0] beats_m1,
  input  logic              mon_en,
  input  logic [LIM_W-1:0]  tmo_limit,
  input  logic              freeze_i,
  input  logic              dbg_req_i,
  output logic              tea_o
);

  localparam logic [LIM_W-1:0] LIM_ONE = LIM_W'(1);

  logic              busy_q, armed_q, tea_q;
  logic [PRE_W-1:0]  pre_q;
  logic [LIM_W-1:0]  cnt_q, lim_q;
  logic [BEAT_W-1:0] left_q;

  wire tick    = &pre_q;
  wire forced  = freeze_i | dbg_req_i;
  wire on      = armed_q | forced;
  wire at_lim  = cnt_q >= lim_q;
  wire hit_nxt = tick && (({1'b0, cnt_q} + 1'b1) >= {1'b0, lim_q});
  wire answer  = xfer_ack | xfer_err | xfer_retry;
  wire fire    = busy_q & on & (at_lim | hit_nxt) & ~answer & ~xfer_start;

  wire [LIM_W-1:0] lim_eff = (tmo_limit == '0) ? LIM_ONE : tmo_limit;

  assign tea_o = tea_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      tea_q   <= 1'b0;
      pre_q   <= '0;
      cnt_q   <= '0;
      lim_q   <= LIM_ONE;
      left_q  <= '0;
    end else begin
      tea_q <= fire;
      if (xfer_start) begin
        busy_q  <= 1'b1;
        armed_q <= mon_en;
        pre_q   <= '0;
        cnt_q   <= '0;
        lim_q   <= lim_eff;
        left_q  <= burst_i ? beats_m1 : '0;
      end else if (busy_q) begin
        if (answer) begin
          if (xfer_ack && !xfer_err && !xfer_retry && left_q != '0) begin
            left_q <= left_q - 1'b1;
            pre_q  <= '0;
            cnt_q  <= '0;
          end else begin
            busy_q <= 1'b0;
          end
        end else if (fire) begin
          busy_q <= 1'b0;
        end else begin
          pre_q <= pre_q + 1'b1;
          if (tick && !at_lim) cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

module bus_timeout_mon_chk #(
  parameter int PRE_W = 3,
  parameter int LIM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_start,
  input logic             xfer_ack,
  input logic             xfer_err,
  input logic             xfer_retry,
  input logic             freeze_i,
  input logic             dbg_req_i,
  input logic             tea_o,
  input logic             busy_q,
  input logic             armed_q,
  input logic [PRE_W-1:0] pre_q,
  input logic [LIM_W-1:0] cnt_q
);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> (busy_q && pre_q == '0 && cnt_q == '0)); // R2

  AST_ANSWER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tea_o |-> !$past(xfer_ack || xfer_err || xfer_retry || xfer_start)); // R3

  AST_TEA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tea_o |=> !tea_o); // R6

  AST_IDLE_AFTER_TEA: assert property (@(posedge clk) disable iff (!rst_n)
    tea_o |-> !busy_q); // R6

  AST_TEA_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tea_o |-> $past(busy_q)); // R5

  AST_NO_TEA_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    tea_o |-> $past(armed_q || freeze_i || dbg_req_i)); // R7

endmodule

bind bus_timeout_mon bus_timeout_mon_chk #(.PRE_W(PRE_W), .LIM_W(LIM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_ack(xfer_ack),
  .xfer_err(xfer_err), .xfer_retry(xfer_retry), .freeze_i(freeze_i),
  .dbg_req_i(dbg_req_i), .tea_o(tea_o), .busy_q(busy_q), .armed_q(armed_q),
  .pre_q(pre_q), .cnt_q(cnt_q)
);

// File: tb/bus_timeout_mon_tb.sv
module bus_timeout_mon_tb_top;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xfer_start = 0, xfer_ack = 0, xfer_err = 0, xfer_retry = 0, burst_i = 0;
  logic [1:0] beats_m1 = '0;
  logic mon_en = 0, freeze_i = 0, dbg_req_i = 0;
  logic [7:0] tmo_limit = 8'd1;
  logic tea_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  bus_timeout_mon dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_ack(xfer_ack),
    .xfer_err(xfer_err), .xfer_retry(xfer_retry), .burst_i(burst_i),
    .beats_m1(beats_m1), .mon_en(mon_en), .tmo_limit(tmo_limit),
    .freeze_i(freeze_i), .dbg_req_i(dbg_req_i), .tea_o(tea_o)
  );

  typedef struct packed {
    logic [7:0]  lim;
    logic        en, frz, dbg, burst;
    logic [1:0]  bm1;
    logic [1:0]  kind;
    logic [11:0] a0, a1, a2;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'd3,   1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 12'd0,  12'd0,  12'd0},
    '{8'd0,   1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 12'd0,  12'd0,  12'd0},
    '{8'd255, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 12'd0,  12'd0,  12'd0},
    '{8'd2,   1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 12'd10, 12'd0,  12'd0},
    '{8'd2,   1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 12'd16, 12'd0,  12'd0},
    '{8'd2,   1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 12'd17, 12'd0,  12'd0},
    '{8'd1,   1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 12'd5,  12'd12, 12'd0},
    '{8'd1,   1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 12'd5,  12'd12, 12'd20},
    '{8'd1,   1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 12'd8,  12'd16, 12'd0},
    '{8'd2,   1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 2'd1, 12'd5,  12'd0,  12'd0},
    '{8'd2,   1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 2'd2, 12'd5,  12'd30, 12'd0},
    '{8'd1,   1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 12'd0,  12'd0,  12'd0},
    '{8'd1,   1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 12'd0,  12'd0,  12'd0},
    '{8'd4,   1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 12'd0,  12'd0,  12'd0},
    '{8'd1,   1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 12'd3,  12'd0,  12'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_obs(output bit t);
    @(posedge clk);
    @(negedge clk);
    t = tea_o;
  endtask

  task automatic run_vec(input vec_t v);
    int ev[3];
    int w, exp, beats, beat, bs, len, first, pulses;
    bit done, on, t;
    string req;
    ev[0] = int'(v.a0); ev[1] = int'(v.a1); ev[2] = int'(v.a2);
    w = 8 * ((v.lim == 0) ? 1 : int'(v.lim));
    on = v.en | v.frz | v.dbg;
    beats = v.burst ? int'(v.bm1) + 1 : 1;
    beat = 0; bs = 0; exp = 0; done = 0;
    for (int i = 0; i < 3 && !done; i++) begin
      if (ev[i] == 0 || ev[i] > bs + w) begin
        exp = on ? bs + w : 0;
        done = 1;
      end else if (v.kind != 0) begin
        done = 1;
      end else begin
        beat++;
        bs = ev[i];
        if (beat == beats) done = 1;
      end
    end
    if (!done) exp = on ? bs + w : 0;
    len = w + 40;
    for (int i = 0; i < 3; i++) if (ev[i] + w + 10 > len) len = ev[i] + w + 10;
    if (v.kind != 0) req = "R5";
    else if (!on) req = "R7";
    else if (!v.en) req = "R8";
    else if (v.burst) req = "R4";
    else if (ev[0] != 0) req = "R3";
    else req = "R2";

    @(negedge clk);
    mon_en = v.en; tmo_limit = v.lim; freeze_i = v.frz; dbg_req_i = v.dbg;
    burst_i = v.burst; beats_m1 = v.bm1; xfer_start = 1;
    @(posedge clk);
    @(negedge clk);
    xfer_start = 0; burst_i = 0;
    first = 0; pulses = 0;
    for (int n = 1; n <= len; n++) begin
      bit hit;
      hit = (n == ev[0]) || (n == ev[1]) || (n == ev[2]);
      xfer_ack = hit && v.kind == 2'd0;
      xfer_err = hit && v.kind == 2'd1;
      xfer_retry = hit && v.kind == 2'd2;
      edge_obs(t);
      if (t) begin
        pulses++;
        if (first == 0) first = n;
      end
    end
    xfer_ack = 0; xfer_err = 0; xfer_retry = 0; freeze_i = 0; dbg_req_i = 0;
    check(first == exp, req, first, exp);
    check(pulses == (exp != 0 ? 1 : 0), "R6", pulses, exp != 0 ? 1 : 0);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit t;
    int first;
    repeat (3) @(negedge clk);
    check(tea_o == 1'b0, "R1", tea_o, 0);
    rst_n = 1;
    @(negedge clk);
    check(tea_o == 1'b0, "R1", tea_o, 0);

    // R5: answers while idle change nothing, then table walk
    xfer_ack = 1; xfer_err = 1;
    edge_obs(t);
    xfer_ack = 0; xfer_err = 0;
    check(t == 1'b0, "R5", t, 0);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R7: enable dropped after start still times out
    @(negedge clk);
    mon_en = 1; tmo_limit = 8'd1; xfer_start = 1;
    @(posedge clk); @(negedge clk);
    xfer_start = 0; mon_en = 0; first = 0;
    for (int n = 1; n <= 20; n++) begin edge_obs(t); if (t && first == 0) first = n; end
    check(first == 8, "R7", first, 8);

    // R8: freeze raised late in a disabled cycle fires on the next edge
    @(negedge clk);
    mon_en = 0; tmo_limit = 8'd1; xfer_start = 1;
    @(posedge clk); @(negedge clk);
    xfer_start = 0; first = 0;
    for (int n = 1; n <= 30; n++) begin
      freeze_i = (n >= 21);
      edge_obs(t);
      if (t && first == 0) first = n;
    end
    freeze_i = 0;
    check(first == 21, "R8", first, 21);

    // R9: second start re-opens the window with the new limit
    @(negedge clk);
    mon_en = 1; tmo_limit = 8'd1; xfer_start = 1;
    @(posedge clk); @(negedge clk);
    xfer_start = 0; first = 0;
    for (int n = 1; n <= 40; n++) begin
      xfer_start = (n == 5);
      tmo_limit = (n == 5) ? 8'd2 : 8'd1;
      edge_obs(t);
      if (t && first == 0) first = n;
    end
    xfer_start = 0;
    check(first == 21, "R9", first, 21);

    // R1: reset mid-cycle returns to idle with no pulse
    @(negedge clk);
    mon_en = 1; tmo_limit = 8'd1; xfer_start = 1;
    @(posedge clk); @(negedge clk);
    xfer_start = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1; first = 0;
    for (int n = 1; n <= 20; n++) begin edge_obs(t); if (t && first == 0) first = n; end
    check(first == 0, "R1", first, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule